// File: doc/BRIEF.md
# Strided Vector Memory Access Sequencer

This block turns one vector load or store command into a stream of word references for an interleaved memory. A command gives a start address, a signed address step, a flag that forces the step to one, and an element count. The sequencer then offers one reference per clock, with its address, bank number and element number, on a valid/ready handshake towards the memory side.

Memory words are spread over the banks by their low-order address bits. After a bank is used it stays busy for a fixed number of clocks. The sequencer keeps a small down-counter per bank and holds back any reference whose bank has not recovered. The step size therefore sets the rate. A step that revisits the same bank on every element gives one word every four clocks. A step that revisits it on every second element gives one word every two clocks. Any step that spaces revisits four or more elements apart gives one word per clock. A single-cycle pulse marks the end of the command.

Top module: `vec_stride_seq`

## Requirements
- R1: The bank index output equals the low log2(NUM_BANKS) bits of the offered address (bits 3:0 with 16 banks).
- R2: The k-th reference (k counting from 0) carries address (base + k*step) modulo 2^ADDR_W, where the step is taken as a two's-complement value, and carries element index k.
- R3: When the unit-step input is high at start, the step is 1 and the step input is ignored.
- R4: A bank that is accepted in cycle t is not offered again before cycle t+4.
- R5: A reference is offered, and accepted if ready is high, in the first cycle in which the previous element has been accepted and its bank has recovered. The first reference is offered in the cycle after start is sampled.
- R6: While valid is high and ready is low, the request stays valid and its address and element index do not change.
- R7: Exactly the commanded number of references is accepted, and done is high for one cycle, in the cycle after the last acceptance.
- R8: A count of zero produces no request and raises done in the cycle after start is sampled.
- R9: A start pulse that arrives while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a command (sampled when idle) |
| base_i | input | ADDR_W | Start word address |
| stride_i | input | ADDR_W | Signed address step |
| unit_stride_i | input | 1 | Use a step of 1 instead of stride_i |
| vlen_i | input | LEN_W | Number of elements |
| req_valid_o | output | 1 | Reference offered |
| req_addr_o | output | ADDR_W | Word address of the reference |
| req_bank_o | output | BANK_W | Bank of the reference |
| req_elem_o | output | LEN_W | Element index of the reference |
| req_ready_i | input | 1 | Memory side accepts the reference |
| done_o | output | 1 | One-cycle end-of-command pulse |

## Verification
The bench sweeps every step from 0 to 17 plus a negative step across the address wrap, and predicts the acceptance cycle of every element from the bank recovery rule. A design with an off-by-one timer reload would shift steps 8 and 16 by a cycle per revisit, and one that decoded the bank from the wrong bits would stall unit steps. Throttled-ready patterns check that a stalled request neither moves nor skips an element, a zero count checks that done comes without any request, and a start pulse during a run checks that the command is not reloaded.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vseq_bank_timers.sv
module vseq_bank_timers #(
  parameter int NUM_BANKS   = 16,
  parameter int BANK_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int TMR_W      = $clog2(BANK_CYCLES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [BANK_W-1:0] hit_bank_i,
  input  logic [BANK_W-1:0] query_bank_i,
  output logic              free_o
);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BANK_CYCLES - 1);

  logic [TMR_W-1:0] cnt_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g] <= '0;
      end else if (hit_i && hit_bank_i == BANK_W'(g)) begin
        cnt_q[g] <= RELOAD;
      end else if (cnt_q[g] != '0) begin
        cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign free_o = (cnt_q[query_bank_i] == '0);

  // R4: a reference is only taken on a bank whose timer has run out
  a_r4_hit_on_free: assert property (@(posedge clk) disable iff (rst)
    hit_i |-> cnt_q[hit_bank_i] == '0);

  // R4: a taken bank is marked busy for the full recovery time
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> cnt_q[$past(hit_bank_i)] == RELOAD);
endmodule

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  elem_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      elem_o <= '0;
    end else if (load_i) begin
      addr_o <= base_i;
      elem_o <= '0;
    end else if (advance_i) begin
      addr_o <= addr_o + step_i;
      elem_o <= elem_o + 1'b1;
    end
  end

  // R6: without an advance or a load, the reference does not move
  a_r6_no_drift: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !advance_i) |=> ($stable(addr_o) && $stable(elem_o)));
endmodule

// File: rtl/vec_stride_seq.sv
module vec_stride_seq #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 8,
  parameter int NUM_BANKS   = 16,
  parameter int BANK_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              unit_stride_i,
  input  logic [LEN_W-1:0]  vlen_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BANK_W-1:0] req_bank_o,
  output logic [LEN_W-1:0]  req_elem_o,
  input  logic              req_ready_i,
  output logic              done_o
);
  import vseq_pkg::*;

  seq_state_e        state_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] step_q;
  logic              bank_free;
  logic              accept;
  logic              last_elem;
  logic              launch;

  assign launch    = (state_q == ST_IDLE) && start_i;
  assign accept    = req_valid_o && req_ready_i;
  assign last_elem = (req_elem_o == LEN_W'(len_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      step_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            len_q  <= vlen_i;
            step_q <= unit_stride_i ? ADDR_W'(1) : stride_i;
            if (vlen_i == '0) done_o  <= 1'b1;
            else              state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept && last_elem) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vseq_addr_gen #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (launch),
    .base_i    (base_i),
    .advance_i (accept),
    .step_i    (step_q),
    .addr_o    (req_addr_o),
    .elem_o    (req_elem_o)
  );

  assign req_bank_o = req_addr_o[BANK_W-1:0];

  vseq_bank_timers #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_CYCLES (BANK_CYCLES)
  ) u_timers (
    .clk          (clk),
    .rst          (rst),
    .hit_i        (accept),
    .hit_bank_i   (req_bank_o),
    .query_bank_i (req_bank_o),
    .free_o       (bank_free)
  );

  assign req_valid_o = (state_q == ST_RUN) && bank_free;

  // R6: a stalled request stays up and unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_elem_o)));

  // R4: no same-bank acceptance one, two or three cycles apart
  a_r4_gap1: assert property (@(posedge clk) disable iff (rst)
    (accept && $past(accept)) |-> req_bank_o != $past(req_bank_o));
  a_r4_gap2: assert property (@(posedge clk) disable iff (rst)
    (accept && $past(accept, 2)) |-> req_bank_o != $past(req_bank_o, 2));
  a_r4_gap3: assert property (@(posedge clk) disable iff (rst)
    (accept && $past(accept, 3)) |-> req_bank_o != $past(req_bank_o, 3));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7/R8: done coincides with no offered request
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_valid_o);
endmodule

// File: tb/vec_stride_seq_tb_top.sv
module vec_stride_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] stride_i = '0;
  logic          unit_stride_i = 1'b0;
  logic [LW-1:0] vlen_i = '0;
  logic          req_valid_o;
  logic [AW-1:0] req_addr_o;
  logic [3:0]    req_bank_o;
  logic [LW-1:0] req_elem_o;
  logic          req_ready_i = 1'b0;
  logic          done_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_stride_seq #(.ADDR_W(AW), .LEN_W(LW), .NUM_BANKS(NB), .BANK_CYCLES(4)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .stride_i(stride_i),
    .unit_stride_i(unit_stride_i), .vlen_i(vlen_i), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_bank_o(req_bank_o), .req_elem_o(req_elem_o),
    .req_ready_i(req_ready_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit rdy(input int c, input int mode);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 2;
      default: return (c % 5) == 0;
    endcase
  endfunction

  // One command; every cycle the offered request is compared with the element
  // due next, and each acceptance must land in the predicted cycle.
  task automatic run_vec(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                         input bit unit, input int len, input int mode, input bit inject);
    int lastb [NB];
    int prev, t0, due;
    logic [AW-1:0] step, ea;
    for (int b = 0; b < NB; b++) lastb[b] = -100;
    step = unit ? AW'(1) : stride;
    @(negedge clk);
    base_i = base; stride_i = stride; unit_stride_i = unit; vlen_i = LW'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
    prev = t0 - 1;
    if (len == 0) begin
      req_ready_i = 1'b1; #1;
      check(done_o == 1'b1, "R8 done after empty start", int'(done_o), 1);
      check(req_valid_o == 1'b0, "R8 no request", int'(req_valid_o), 0);
      repeat (3) begin
        @(negedge clk); #1;
        check(req_valid_o == 1'b0 && done_o == 1'b0, "R8 stays quiet",
              int'(req_valid_o) + int'(done_o), 0);
      end
      return;
    end
    for (int k = 0; k < len; k++) begin
      ea = base + AW'(k) * step;
      due = prev + 1;
      if (lastb[ea[3:0]] + 4 > due) due = lastb[ea[3:0]] + 4;
      while (!rdy(due, mode)) due++;
      forever begin
        if (inject && cyc == t0 + 1) begin
          start_i = 1'b1; base_i = 16'h7777; vlen_i = 8'd2; unit_stride_i = 1'b1;
        end else begin
          start_i = 1'b0;
        end
        req_ready_i = rdy(cyc, mode);
        #1;
        if (cyc < due) begin
          check(!(req_valid_o && req_ready_i), "R5 no early acceptance", int'(req_valid_o), 0);
          if (req_valid_o)
            check(req_addr_o == ea && req_elem_o == LW'(k), "R6 stalled request held",
                  int'(req_addr_o), int'(ea));
          check(done_o == 1'b0, "R7 no early done", int'(done_o), 0);
          @(negedge clk);
        end else begin
          check(req_valid_o == 1'b1, "R5 offered when due", int'(req_valid_o), 1);
          check(req_addr_o == ea, "R2 address", int'(req_addr_o), int'(ea));
          check(req_bank_o == ea[3:0], "R1 bank from low bits", int'(req_bank_o), int'(ea[3:0]));
          check(req_elem_o == LW'(k), "R2 element index", int'(req_elem_o), k);
          lastb[ea[3:0]] = cyc;
          prev = cyc;
          @(negedge clk);
          break;
        end
      end
    end
    start_i = 1'b0;
    req_ready_i = 1'b1; #1;
    check(done_o == 1'b1, "R7 done one cycle after last", int'(done_o), 1);
    check(req_valid_o == 1'b0, "R7 no request past count", int'(req_valid_o), 0);
    @(negedge clk); #1;
    check(done_o == 1'b0 && req_valid_o == 1'b0, "R7 single pulse, R9 no reload",
          int'(done_o) + int'(req_valid_o), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(req_valid_o == 1'b0, "reset valid", int'(req_valid_o), 0);
    check(done_o == 1'b0, "reset done", int'(done_o), 0);
    // R4/R5: full stride sweep, always ready (16 -> 1/4, 8 -> 1/2 rate)
    for (int s = 0; s <= 17; s++) run_vec(16'h0005, AW'(s), 1'b0, 20, 0, 1'b0);
    // R2: negative step crossing the address wrap
    run_vec(16'h0002, 16'hFFFD, 1'b0, 12, 0, 1'b0);
    // R3: unit flag overrides a same-bank step
    run_vec(16'h00F0, 16'h0010, 1'b1, 18, 0, 1'b0);
    // R8 and single element
    run_vec(16'h0100, 16'h0001, 1'b0, 0, 0, 1'b0);
    run_vec(16'hFFFF, 16'h0010, 1'b0, 1, 0, 1'b0);
    // R6: throttled ready patterns
    run_vec(16'h0003, 16'h0008, 1'b0, 14, 1, 1'b0);
    run_vec(16'h0003, 16'h0001, 1'b0, 14, 2, 1'b0);
    run_vec(16'h0000, 16'h0010, 1'b0, 6, 1, 1'b0);
    // R9: start pulse during a run
    run_vec(16'h0040, 16'h0003, 1'b0, 9, 1, 1'b1);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end
endmodule